// File: doc/BRIEF.md
# UART Receive Byte Queue

This block is the small holding queue between a UART's serial receiver and the CPU-visible receive-buffer register. Received bytes enter through a valid/ready stream port and are stored in a circular buffer of `DEPTH` entries, four by default. A CPU read strobe removes the oldest byte. Two plain status outputs report that at least one byte is waiting and that the queue is full.

Upstream flow control uses the stream's ready signal. The receiver hands over a byte only in a cycle where `in_valid` and `in_ready` are both high. Otherwise it holds the byte, and no byte is ever lost through a handshake. A line-break event arrives on its own pulse input. It enters the queue as a zero byte even when the receiver is disabled. When the queue is full, that zero byte replaces the newest stored byte instead of being dropped. The receiver-reset command drives `rx_clear`, which empties the queue in one cycle.

Top module: `uart_rx_queue`

## Requirements
- R1: Bytes leave the queue in arrival order. `rd_data` always shows the oldest stored byte, and a cycle with `rd_en` high and `has_data` high removes that byte at the clock edge.
- R2: Any byte that enters the queue, whether a stream byte or a break, makes `has_data` high after that clock edge.
- R3: `rx_full` goes high after the edge at which the stored count reaches `DEPTH`.
- R4: A removal with no entry in the same cycle makes `rx_full` low after the edge. `has_data` stays high unless the count reaches zero.
- R5: While the queue is empty, `rd_data` is 0x00. A read strobe in that state changes neither the count nor the flags.
- R6: A `brk_evt` pulse enters a 0x00 byte. If the queue is full and nothing is removed in that cycle, the zero replaces the newest entry and the count stays at `DEPTH`.
- R7: A stream byte presented while the queue is full is not accepted (`in_ready` low), so it never overwrites stored data.
- R8: `in_ready` is high only when `rx_enable` is high, `rx_full` is low, and neither `brk_evt` nor `rx_clear` is high in that cycle.
- R9: `rx_clear` empties the queue: after the edge, `has_data` and `rx_full` are low. It takes priority over any entry or removal in the same cycle.
- R10: An entry and a removal in the same cycle on a non-empty queue leave the count and both flags unchanged.
- R11: A break takes priority over a stream byte in the same cycle. `in_ready` is low while `brk_evt` is high.
- R12: After reset the queue is empty: `has_data` and `rx_full` are low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enabled; gates stream acceptance |
| rx_clear | input | 1 | Receiver-reset command; empties the queue |
| in_valid | input | 1 | Stream byte offered |
| in_data | input | WIDTH (8) | Stream byte |
| in_ready | output | 1 | Queue takes the offered byte this cycle |
| brk_evt | input | 1 | Line-break event; enters a zero byte |
| rd_en | input | 1 | CPU read of the receive buffer |
| rd_data | output | WIDTH (8) | Oldest byte, 0x00 when empty |
| has_data | output | 1 | At least one byte stored |
| rx_full | output | 1 | DEPTH bytes stored |

## Verification
`in_ready` and `rd_data` are combinational and respond within the cycle in which their inputs change. The bench therefore drives inputs on the falling edge and compares these two outputs one time unit later, before the rising edge. `has_data`, `rx_full` and the head byte take one register stage, so they are compared one time unit after the rising edge that applied the operation. A bench queue model supplies every expected value. The sweep starts from each fill level, zero to four, and applies every combination of the five control inputs. Each sweep step is followed by a full drain that checks byte order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Operation chosen for the current cycle by the admission logic.
  typedef enum logic [2:0] {
    RXQ_IDLE  = 3'd0,
    RXQ_PUSH  = 3'd1,
    RXQ_POP   = 3'd2,
    RXQ_SWAP  = 3'd3,  // push and pop together
    RXQ_OVWR  = 3'd4,  // break into a full queue: replace newest
    RXQ_CLEAR = 3'd5
  } rxq_op_e;
endpackage

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic             brk_evt,
  input  logic             rd_en,
  input  logic             rx_enable,
  input  logic             rx_clear,
  input  logic [CW-1:0]    count,
  output logic             in_ready,
  output rxq_op_e          op,
  output logic [WIDTH-1:0] wr_byte
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic is_empty, is_full, take_push, take_pop;

  assign is_empty = (count == '0);
  assign is_full  = (count == FULL_CNT);

  // Stream handshake: break and clear both steal the cycle.
  assign in_ready  = rx_enable && !is_full && !brk_evt && !rx_clear;
  assign take_push = brk_evt || (in_valid && in_ready);
  assign take_pop  = rd_en && !is_empty;
  assign wr_byte   = brk_evt ? '0 : in_data;

  always_comb begin
    if (rx_clear)                 op = RXQ_CLEAR;
    else if (take_push && take_pop) op = RXQ_SWAP;
    else if (take_push && is_full)  op = RXQ_OVWR;
    else if (take_push)             op = RXQ_PUSH;
    else if (take_pop)              op = RXQ_POP;
    else                            op = RXQ_IDLE;
  end

  // R7: no stream byte is accepted into a full queue
  a_r7_full_blocks_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> !in_ready);
  // R11: a break always wins the cycle over the stream
  a_r11_break_priority: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> (!in_ready && (op != RXQ_POP) && (op != RXQ_IDLE)));
  // R5: a read of an empty queue never becomes a removal
  a_r5_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && count == '0) |-> (op != RXQ_POP && op != RXQ_SWAP));
  // R8: acceptance requires an enabled receiver
  a_r8_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> rx_enable);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxq_op_e       op,
  output logic [CW-1:0] count,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc, newest_idx;
  logic [CW-1:0] count_q;

  assign wr_ptr_inc = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + PW'(1);
  assign rd_ptr_inc = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + PW'(1);
  assign newest_idx = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - PW'(1);

  assign wr_en  = (op == RXQ_PUSH) || (op == RXQ_SWAP) || (op == RXQ_OVWR);
  assign wr_idx = (op == RXQ_OVWR) ? newest_idx : wr_ptr_q;
  assign rd_idx = rd_ptr_q;
  assign count  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      unique case (op)
        RXQ_CLEAR: begin
          wr_ptr_q <= '0;
          rd_ptr_q <= '0;
          count_q  <= '0;
        end
        RXQ_PUSH: begin
          wr_ptr_q <= wr_ptr_inc;
          count_q  <= count_q + CW'(1);
        end
        RXQ_POP: begin
          rd_ptr_q <= rd_ptr_inc;
          count_q  <= count_q - CW'(1);
        end
        RXQ_SWAP: begin
          wr_ptr_q <= wr_ptr_inc;
          rd_ptr_q <= rd_ptr_inc;
        end
        default: ;  // IDLE and OVWR keep pointers and count
      endcase
    end
  end

  // R3: the count never passes the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);
  // R6: an overwrite happens only on a full queue and keeps it full
  a_r6_overwrite_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RXQ_OVWR) |-> (count_q == FULL_CNT) ##1 (count_q == FULL_CNT));
  // R10: simultaneous entry and removal keep the count
  a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RXQ_SWAP) |=> $stable(count_q));
  // R9: clear empties the queue in one edge
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RXQ_CLEAR) |=> (count_q == '0));
  // R5: no removal from an empty queue
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |-> (op != RXQ_POP && op != RXQ_SWAP));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_byte,
  input  logic [PW-1:0]    rd_idx,
  output logic [WIDTH-1:0] head
);
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot_dec
    assign slot_we[e] = wr_en && (wr_idx == PW'(e));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (slot_we[e]) slot_q[e] <= wr_byte;
    end
  end

  assign head = slot_q[rd_idx];
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             rx_clear,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             brk_evt,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             has_data,
  output logic             rx_full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rxq_op_e          op;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] wr_byte, head;
  logic             wr_en;
  logic [PW-1:0]    wr_idx, rd_idx;

  rxq_admit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_admit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .brk_evt(brk_evt), .rd_en(rd_en), .rx_enable(rx_enable),
    .rx_clear(rx_clear), .count(count), .in_ready(in_ready), .op(op),
    .wr_byte(wr_byte));

  rxq_ctrl #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .count(count), .wr_en(wr_en),
    .wr_idx(wr_idx), .rd_idx(rd_idx));

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .rd_idx(rd_idx), .head(head));

  assign has_data = (count != '0);
  assign rx_full  = (count == FULL_CNT);
  assign rd_data  = has_data ? head : '0;

  // R2: an accepted byte or a break leaves data waiting
  a_r2_entry_sets_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_clear && (brk_evt || (in_valid && in_ready))) |=> has_data);
  // R4: a lone removal drops the full flag
  a_r4_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && has_data && !rx_clear && !brk_evt && !(in_valid && in_ready))
      |=> !rx_full);
  // R5: an empty queue reads as zero
  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data |-> (rd_data == '0));
  // R9: clear drops both flags
  a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clear |=> (!has_data && !rx_full));
endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_enable = 0, rx_clear = 0, in_valid = 0, brk_evt = 0, rd_en = 0;
  logic [7:0] in_data = '0;
  logic in_ready, has_data, rx_full;
  logic [7:0] rd_data;

  int n_run = 0, n_fail = 0;
  logic [7:0] mq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH), .WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_clear(rx_clear),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .brk_evt(brk_evt), .rd_en(rd_en), .rd_data(rd_data),
    .has_data(has_data), .rx_full(rx_full));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check combinational outputs,
  // apply at rising edge, then check flags against the model.
  task automatic step(input logic v, input logic [7:0] d, input logic b,
                      input logic r, input logic e, input logic c);
    int sz;
    bit exp_rdy, pushed, popped;
    logic [7:0] byte_in;
    string tg;
    @(negedge clk);
    in_valid = v; in_data = d; brk_evt = b; rd_en = r;
    rx_enable = e; rx_clear = c;
    #1;
    sz = mq.size();
    exp_rdy = e && (sz < DEPTH) && !b && !c;
    check(sz == 0 ? "R5 empty rd_data" : "R1 head rd_data",
          rd_data, sz == 0 ? 0 : mq[0]);
    check(b ? "R11 in_ready" : (sz == DEPTH ? "R7 in_ready" : "R8 in_ready"),
          in_ready, exp_rdy);
    @(posedge clk);
    #1;
    pushed = !c && (b || (v && exp_rdy));
    popped = !c && r && (sz > 0);
    byte_in = b ? 8'h00 : d;
    if (c) tg = "R9";
    else if (pushed && popped) tg = "R10";
    else if (b) tg = "R6";
    else if (pushed && sz == DEPTH - 1) tg = "R3";
    else if (pushed) tg = "R2";
    else if (popped) tg = "R4";
    else tg = "R5";
    if (c) mq.delete();
    else begin
      if (popped) void'(mq.pop_front());
      if (pushed) begin
        if (mq.size() == DEPTH) mq[DEPTH-1] = byte_in;
        else mq.push_back(byte_in);
      end
    end
    check({tg, " has_data"}, has_data, mq.size() > 0);
    check({tg, " rx_full"}, rx_full, mq.size() == DEPTH);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(0, 8'h00, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rx_enable = 1'b1;
    #1;
    // R12: reset state
    check("R12 has_data", has_data, 0);
    check("R12 rx_full", rx_full, 0);
    check("R12 rd_data", rd_data, 0);
    check("R12 in_ready", in_ready, 1);

    // R6 directed: break into a full queue replaces the newest byte
    for (int k = 0; k < DEPTH; k++) step(1, 8'h51 + 8'(k), 0, 0, 1, 0);
    step(1, 8'h77, 0, 0, 1, 0);          // R7: dropped while full
    step(0, 8'h00, 1, 0, 1, 0);
    for (int k = 0; k < DEPTH - 1; k++) step(0, 8'h00, 0, 1, 1, 0);
    check("R6 overwritten newest", rd_data, 0);
    check("R6 one left", has_data, 1);
    drain();
    step(0, 8'h00, 0, 1, 1, 0);          // R5: empty read changes nothing

    // Sweep: every fill level, every control combination
    for (int c0 = 0; c0 <= DEPTH; c0++) begin
      for (int m = 0; m < 32; m++) begin
        step(0, 8'h00, 0, 0, 0, 1);
        for (int k = 0; k < c0; k++) step(1, 8'(16 * c0 + k + 1), 0, 0, 1, 0);
        step(m[0], 8'hA0 | 8'(m), m[1], m[2], m[3], m[4]);
        drain();
      end
    end

    // Long pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[15:8], (lfsr[3:1] == 3'b101),
           lfsr[2] & lfsr[6], lfsr[4] | lfsr[7], (lfsr[11:7] == 5'h1F));
    end
    drain();

    @(negedge clk);
    in_valid = 0; brk_evt = 0; rd_en = 0; rx_clear = 0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule